// File: doc/BRIEF.md
# Logical Address Route Lookup

This block sits at the front of a ten-port packet switch and decides where each packet goes. The switch has eight serial links, two parallel host ports and one internal configuration port, which gives eleven port numbers: 0 for configuration, 1 to 8 for the links and 9 to 10 for the hosts. When the leading byte of a new packet is presented, the block classifies it and returns one registered result. The byte may be a configuration address, a direct physical port number, a reserved value or a logical address. The result is either a destination port with priority and header-strip attributes, or a decision to spill the packet.

Logical addresses 32 to 255 are resolved through a writable table. Each entry names a group of candidate output ports. The block steers the packet to a candidate that is currently free, which gives adaptive routing across redundant links. Entries also carry a high/low priority bit for the arbiter and a flag that strips the address byte. The strip flag supports regional addressing. A sticky error flag records every spilled header until configuration clears it.

Top module: `route_lut`

## Requirements
- R1: A header byte of 0 yields port 0, priority low, strip set, no spill.
- R2: After reset every table entry is invalid, so every header byte from 32 to 255 spills.
- R3: A header byte from 1 to 10 yields that port number, priority low, strip set, no spill, whatever the readiness inputs are.
- R4: A header byte from 11 to 31 spills.
- R5: A write loads the entry for `wr_addr` with `wr_data`, where bits [10:0] are a port mask (bit i is port i), bit 11 is priority (1 = high) and bit 12 is strip. A write to an address below 32 has no effect.
- R6: For a logical entry, the chosen port is the lowest-numbered mask member whose `port_ready` bit is set. If no member is ready, the lowest-numbered member is chosen.
- R7: For a valid logical entry, `res_pri` and `res_del` equal the entry's priority and strip bits.
- R8: An entry with an all-zero mask spills. A spill result has port 0, priority 0 and strip 0.
- R9: `res_valid` is high in exactly the cycle after each cycle in which `hdr_valid` is high, and carries that header's result. Back-to-back headers give back-to-back results.
- R10: `err_flag` is 0 after reset. It rises together with any spill result and stays set until `err_clr`. If `err_clr` and a spill occur in the same cycle, the flag stays set.
- R11: A lookup in the same cycle as a write to the same entry returns the entry's previous contents.
- R12: Rewriting an entry with an all-zero mask makes it spill again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Logical address of the entry written |
| wr_data | input | 13 | Entry: {strip, priority, port mask[10:0]} |
| hdr_valid | input | 1 | Leading packet byte present this cycle |
| hdr_byte | input | 8 | Leading packet byte |
| port_ready | input | 11 | Per-port free indication, bit i for port i |
| err_clr | input | 1 | Clears the sticky error flag |
| res_valid | output | 1 | Lookup result valid |
| res_port | output | 4 | Chosen destination port |
| res_pri | output | 1 | High priority |
| res_del | output | 1 | Strip the leading byte before forwarding |
| res_spill | output | 1 | Discard the packet up to its end marker |
| err_flag | output | 1 | Sticky invalid-address flag |

## Verification
The hardest case to reach is a lookup that meets a write to the same entry in the same cycle. The outcome depends on the table being read before the write lands, and a sequential driver never lines the two up by accident. The stimulus therefore sets the write and the header in one driver step, and the scoreboard expects the stale entry followed by the new one. It is also hard to drive a clear and a spill into one cycle so that the set-over-clear precedence shows. The bench does this by raising `err_clr` alongside a reserved-address header. Adaptive choice is covered by walking the readiness mask through a set that includes none ready, only a non-member ready, a single member ready and several members ready.

// File: rtl/route_lut.sv
module route_lut #(
  parameter int NPORT    = 11,
  parameter int AW       = 8,
  parameter int LOG_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [NPORT+1:0]   wr_data,
  input  logic               hdr_valid,
  input  logic [AW-1:0]      hdr_byte,
  input  logic [NPORT-1:0]   port_ready,
  input  logic               err_clr,
  output logic               res_valid,
  output logic [$clog2(NPORT)-1:0] res_port,
  output logic               res_pri,
  output logic               res_del,
  output logic               res_spill,
  output logic               err_flag
);
  localparam int PW    = $clog2(NPORT);
  localparam int EW    = NPORT + 2;
  localparam int DEPTH = (1 << AW) - LOG_BASE;
  localparam int IW    = $clog2(DEPTH);

  logic [EW-1:0] tbl [DEPTH];

  logic [AW-1:0] widx, ridx;
  assign widx = wr_addr - AW'(LOG_BASE);
  assign ridx = hdr_byte - AW'(LOG_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en && wr_addr >= AW'(LOG_BASE)) begin
      tbl[widx[IW-1:0]] <= wr_data;
    end
  end

  function automatic logic [PW-1:0] lowest(input logic [NPORT-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (m[i]) r = PW'(i);
    return r;
  endfunction

  logic [EW-1:0]    ent;
  logic             is_phys, is_log, spill;
  logic [NPORT-1:0] mask, cand;
  logic [PW-1:0]    pick;

  assign ent     = tbl[ridx[IW-1:0]];
  assign is_phys = hdr_byte < AW'(NPORT);
  assign is_log  = hdr_byte >= AW'(LOG_BASE);
  assign mask    = is_phys ? (NPORT'(1) << hdr_byte)
                 : is_log  ? ent[NPORT-1:0] : '0;
  assign spill   = ~|mask;
  assign cand    = mask & port_ready;
  assign pick    = |cand ? lowest(cand) : lowest(mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_port  <= '0;
      res_pri   <= 1'b0;
      res_del   <= 1'b0;
      res_spill <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      res_valid <= hdr_valid;
      if (hdr_valid) begin
        res_spill <= spill;
        res_port  <= spill ? '0 : pick;
        res_pri   <= !spill && is_log && ent[NPORT];
        res_del   <= !spill && (is_phys || ent[NPORT+1]);
      end
      if (hdr_valid && spill) err_flag <= 1'b1;
      else if (err_clr)       err_flag <= 1'b0;
    end
  end
endmodule

module route_lut_chk #(
  parameter int NPORT = 11,
  parameter int AW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     hdr_valid,
  input logic [AW-1:0]            hdr_byte,
  input logic                     err_clr,
  input logic                     res_valid,
  input logic [$clog2(NPORT)-1:0] res_port,
  input logic                     res_pri,
  input logic                     res_del,
  input logic                     res_spill,
  input logic                     err_flag
);
  // R9
  hdr_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_valid);
  // R9
  idle_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid);
  // R1
  cfg_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_byte == '0 |=> res_port == '0 && !res_spill && res_del);
  // R8
  spill_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_spill |-> res_port == '0 && !res_pri && !res_del);
  // R10
  spill_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_spill |-> err_flag);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_flag || (res_valid && res_spill));
  // R6
  port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_spill |-> res_port < NPORT);
endmodule

bind route_lut route_lut_chk #(.NPORT(NPORT), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
  .err_clr(err_clr), .res_valid(res_valid), .res_port(res_port),
  .res_pri(res_pri), .res_del(res_del), .res_spill(res_spill),
  .err_flag(err_flag)
);

// File: tb/route_lut_test.sv
module route_lut_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [12:0] wr_data = 0;
  logic        hdr_valid = 0;
  logic [7:0]  hdr_byte = 0;
  logic [10:0] port_ready = 0;
  logic        err_clr = 0;
  logic        res_valid, res_pri, res_del, res_spill, err_flag;
  logic [3:0]  res_port;

  route_lut uut (.*);

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  logic [12:0] shadow [256];
  logic [6:0]  exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {spill, pri, del, port[3:0]}
  function automatic logic [6:0] model(input logic [7:0] b, input logic [10:0] rdy);
    logic [10:0] m;
    logic [12:0] e;
    int p;
    if (b <= 10) return {3'b001, b[3:0]};
    if (b < 32) return 7'h40;
    e = shadow[b];
    m = e[10:0];
    if (m == 0) return 7'h40;
    p = -1;
    for (int i = 0; i < 11; i++) if (p < 0 && m[i] && rdy[i]) p = i;
    for (int i = 0; i < 11; i++) if (p < 0 && m[i]) p = i;
    return {1'b0, e[11], e[12], 4'(p)};
  endfunction

  task automatic lookup(input logic [7:0] b, input logic [10:0] rdy, input string tag);
    hdr_valid = 1; hdr_byte = b; port_ready = rdy;
    exp_q.push_back(model(b, rdy));
    tag_q.push_back(tag);
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic write(input logic [7:0] a, input logic [12:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a >= 32) shadow[a] = d;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected result", 1, 0);
      else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_spill, res_pri, res_del, res_port} == e, t,
              {res_spill, res_pri, res_del, res_port}, e);
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R9 reset res_valid", res_valid, 0);
    check(err_flag == 0, "R10 reset err_flag", err_flag, 0);
    rst_n = 1;
    @(negedge clk);

    for (int a = 32; a < 256; a++) lookup(8'(a), 11'h7ff, "R2 invalid after reset");
    check(err_flag == 1, "R10 err after spill", err_flag, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    check(err_flag == 0, "R10 err cleared", err_flag, 0);

    lookup(8'd0, 11'h000, "R1 config port");
    for (int a = 1; a <= 10; a++) lookup(8'(a), 11'h000, "R3 physical port");
    check(err_flag == 0, "R10 no err on good routes", err_flag, 0);
    for (int a = 11; a < 32; a++) lookup(8'(a), 11'h7ff, "R4 reserved spill");
    err_clr = 1; @(negedge clk); err_clr = 0;

    write(8'd5, 13'h0008);
    lookup(8'd5, 11'h7ff, "R5 low write ignored");

    write(8'd64, {1'b0, 1'b1, 11'b010_0100_1000});
    lookup(8'd64, 11'h000, "R6 none ready lowest member");
    lookup(8'd64, 11'h040, "R6 single member ready");
    lookup(8'd64, 11'h240, "R6 lowest ready member");
    lookup(8'd64, 11'h200, "R6 high member ready");
    lookup(8'd64, 11'h004, "R6 nonmember ready");

    write(8'd100, {1'b1, 1'b0, 11'b100_0000_0000});
    lookup(8'd100, 11'h7ff, "R7 strip low priority");
    write(8'd255, {1'b1, 1'b1, 11'b000_0000_0011});
    lookup(8'd255, 11'h002, "R7 strip high priority");
    write(8'd32, {1'b0, 1'b0, 11'b000_0001_0000});
    lookup(8'd32, 11'h7ff, "R5 first logical entry");

    wr_en = 1; wr_addr = 8'd70; wr_data = 13'h0010;
    lookup(8'd70, 11'h7ff, "R11 same-cycle write old value");
    wr_en = 0; shadow[70] = 13'h0010;
    lookup(8'd70, 11'h7ff, "R11 new value after write");

    write(8'd64, 13'h0000);
    lookup(8'd64, 11'h7ff, "R12 rewritten invalid");
    check(err_flag == 1, "R8 zero mask raises err", err_flag, 1);

    err_clr = 1;
    lookup(8'd20, 11'h7ff, "R4 spill with clear");
    err_clr = 0;
    check(err_flag == 1, "R10 set wins over clear", err_flag, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    check(err_flag == 0, "R10 clear alone", err_flag, 0);
    lookup(8'd100, 11'h000, "R7 repeat lookup");
    check(err_flag == 0, "R10 stays clear", err_flag, 0);

    @(negedge clk);
    check(res_valid == 0, "R9 idle no result", res_valid, 0);
    check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule